// File: doc/BRIEF.md
# Float-to-Unsigned-Halfword Rounding Converter

This execution unit serves a single coprocessor instruction. It reads an IEEE-754 single-precision value from one of eight 32-bit registers and turns it into an unsigned 16-bit integer, using round-to-nearest with ties going to the even neighbour. The result is written back to a destination register. The low half of that register takes the integer and the high half is cleared. Every other instruction word on the issue port is ignored.

The unit has two register stages. The first captures the source operand and the destination index when a matching word is issued. The second computes the rounded value and presents a one-cycle write-back. This gives a single delay slot: the instruction issued right after the conversion sees the old destination contents. The program must avoid that hazard itself. Values that cannot be represented are handled as follows: negative values and NaN give zero, and values too large for 16 bits, including +infinity, give the maximum code.

Top module: `fp_to_u16_rne`

## Requirements
- R1: A word is accepted only when `issue_valid` is high, bits 15:0 equal 0xE68E and bits 31:22 equal 10'b1000000000. Any other word, and any cycle without `issue_valid`, produces no write-back.
- R2: An accepted word issued at clock edge k gives `wb_en` high for exactly the cycle after edge k+1. `wb_en` is low after edge k, which is the delay slot.
- R3: The destination index comes from word bits 18:16 and the source index from bits 21:19. `wb_idx` equals the destination index, and `wb_data[31:16]` is always 0x0000.
- R4: Finite positive inputs round to the nearest integer, with exact halves going to the even value. Examples: 10.8→11, 1.5→2, 2.5→2, 3.5→4, 0.75→1.
- R5: Every negative input gives 0x0000. This includes -0 and values such as -10.8.
- R6: Positive inputs whose rounded value exceeds 65535, and +infinity, give 0xFFFF. For example, 65535.5 gives 0xFFFF while 65534.5 gives 0xFFFE.
- R7: NaN inputs, with either sign, give 0x0000.
- R8: Zero, denormals, magnitudes below 0.5, and exactly 0.5 all give 0x0000. A value just above 0.5 gives 1.
- R9: Back-to-back accepted words produce write-backs on consecutive cycles, in issue order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_valid | input | 1 | Instruction word is valid this cycle |
| issue_word | input | 32 | Instruction word |
| regs_flat | input | 256 | Eight 32-bit registers; register n occupies bits 32n+31:32n |
| wb_en | output | 1 | Write-back strobe |
| wb_idx | output | 3 | Destination register index |
| wb_data | output | 32 | Value to write |

## Verification
Each conversion result is due two edges after its word is issued. The bench drives words on the falling edge and samples `wb_en`, `wb_idx` and `wb_data` on the falling edge two cycles later. In the cycle between, it confirms that no write-back has appeared yet, which is the delay slot. For rejected words, the bench watches three full cycles to confirm that nothing is written. For back-to-back issue, it samples two consecutive falling edges to check both order and data.

// File: rtl/fp_to_u16_rne.sv
module fp_to_u16_rne #(
  parameter int NREGS = 8,
  parameter int XLEN  = 32,
  parameter int IW    = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  issue_valid,
  input  logic [31:0]           issue_word,
  input  logic [NREGS*XLEN-1:0] regs_flat,
  output logic                  wb_en,
  output logic [$clog2(NREGS)-1:0] wb_idx,
  output logic [XLEN-1:0]       wb_data
);
  localparam int AW = $clog2(NREGS);
  localparam logic [15:0] LO_OP = 16'hE68E;
  localparam logic [9:0]  HI_OP = 10'b1000000000;
  localparam int BIAS = 127;
  localparam logic [IW-1:0] MAXV = '1;

  // decode
  logic hit;
  logic [AW-1:0] dst, src;
  assign hit = issue_valid && issue_word[15:0] == LO_OP && issue_word[31:22] == HI_OP;
  assign dst = issue_word[16 +: AW];
  assign src = issue_word[19 +: AW];

  // stage one
  logic          s1_v;
  logic [AW-1:0] s1_idx;
  logic [31:0]   s1_op;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1_v <= 1'b0; s1_idx <= '0; s1_op <= '0;
    end else begin
      s1_v <= hit;
      if (hit) begin
        s1_idx <= dst;
        s1_op  <= regs_flat[src*XLEN +: 32];
      end
    end

  // conversion
  logic        sgn;
  logic [7:0]  ex;
  logic [22:0] man;
  assign sgn = s1_op[31];
  assign ex  = s1_op[30:23];
  assign man = s1_op[22:0];

  logic [4:0]  sh;
  logic [47:0] wide;
  logic [23:0] ipart;
  logic        grd, stk, up;
  logic [IW:0] rsum;
  logic [IW-1:0] conv;

  assign sh    = 5'(BIAS + 23 - int'(ex));
  assign wide  = {1'b1, man, 24'b0} >> sh;
  assign ipart = wide[47:24];
  assign grd   = wide[23];
  assign stk   = |wide[22:0];
  assign up    = grd && (stk || ipart[0]);
  assign rsum  = {1'b0, ipart[IW-1:0]} + (IW+1)'(up);

  always_comb begin
    if (ex == 8'hFF && man != 0)             conv = '0;
    else if (sgn)                            conv = '0;
    else if (ex == 8'hFF)                    conv = MAXV;
    else if (int'(ex) < BIAS - 1)            conv = '0;
    else if (int'(ex) > BIAS + IW - 1)       conv = MAXV;
    else if (rsum[IW])                       conv = MAXV;
    else                                     conv = rsum[IW-1:0];
  end

  // stage two
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wb_en <= 1'b0; wb_idx <= '0; wb_data <= '0;
    end else begin
      wb_en <= s1_v;
      if (s1_v) begin
        wb_idx  <= s1_idx;
        wb_data <= {{(XLEN-IW){1'b0}}, conv};
      end
    end

  // R1
  no_spurious_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_valid |=> !s1_v);
  // R2
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> $past(issue_valid, 2));
  // R3
  high_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> wb_data[XLEN-1:IW] == '0);
  // R5
  neg_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_v && s1_op[31]) |=> wb_data == '0);
  // R6
  inf_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_v && s1_op == 32'h7F800000) |=> wb_data[IW-1:0] == MAXV);
  // R9
  b2b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_v && $past(s1_v)) |-> wb_en);
endmodule

// File: tb/tb_fp_to_u16_rne.sv
module tb_fp_to_u16_rne;
  localparam int CLK_NS = 10;
  localparam int NV = 20;

  logic clk = 0, rst_n = 0, issue_valid = 0;
  logic [31:0] issue_word = 0;
  logic [255:0] regs_flat = 0;
  logic wb_en;
  logic [2:0] wb_idx;
  logic [31:0] wb_data;
  int errs = 0, checks = 0;

  fp_to_u16_rne dut (.clk, .rst_n, .issue_valid, .issue_word, .regs_flat,
                     .wb_en, .wb_idx, .wb_data);

  always #(CLK_NS/2) clk = ~clk;

  // operand, expected low half, requirement
  localparam logic [31:0] VIN [NV] = '{
    32'h412CCCCD, 32'h3FC00000, 32'h40200000, 32'h40600000, 32'h3F400000,
    32'hC12CCCCD, 32'h80000000, 32'hBF000001,
    32'h477FFF80, 32'h477FFE80, 32'h47800000, 32'h7F800000, 32'h477FFF00,
    32'h7FC00000, 32'hFFC00001,
    32'h00000000, 32'h00000001, 32'h3EFFFFFF, 32'h3F000000, 32'h3F000001};
  localparam logic [15:0] VOUT [NV] = '{
    16'd11, 16'd2, 16'd2, 16'd4, 16'd1,
    16'd0, 16'd0, 16'd0,
    16'hFFFF, 16'hFFFE, 16'hFFFF, 16'hFFFF, 16'hFFFF,
    16'd0, 16'd0,
    16'd0, 16'd0, 16'd0, 16'd0, 16'd1};
  localparam logic [3:0] VREQ [NV] = '{
    4, 4, 4, 4, 4, 5, 5, 5, 6, 6, 6, 6, 6, 7, 7, 8, 8, 8, 8, 8};

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mkword(input logic [2:0] d, input logic [2:0] s);
    return {10'b1000000000, s, d, 16'hE68E};
  endfunction

  task automatic load(input logic [2:0] s, input logic [31:0] v);
    for (int r = 0; r < 8; r++) regs_flat[r*32 +: 32] = 32'hA5A50000 | r;
    regs_flat[s*32 +: 32] = v;
  endtask

  initial begin
    #(CLK_NS*50000);
    errs++; checks++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(wb_en == 0, "R2 reset", 32'(wb_en), 0);
    rst_n = 1;
    @(negedge clk);

    // table walk: R3 R4 R5 R6 R7 R8 with varying indices
    for (int i = 0; i < NV; i++) begin
      logic [2:0] s, d;
      s = 3'(i); d = 3'(i + 3);
      load(s, VIN[i]);
      issue_valid = 1; issue_word = mkword(d, s);
      @(negedge clk);
      issue_valid = 0; issue_word = 0;
      chk(wb_en == 0, "R2 delay slot", 32'(wb_en), 0);
      @(negedge clk);
      chk(wb_en == 1, "R2 latency", 32'(wb_en), 1);
      chk(wb_idx == d, "R3 index", 32'(wb_idx), 32'(d));
      chk(wb_data == {16'h0, VOUT[i]}, $sformatf("R%0d value", VREQ[i]), wb_data, {16'h0, VOUT[i]});
      @(negedge clk);
      chk(wb_en == 0, "R2 one cycle", 32'(wb_en), 0);
    end

    // R1: rejected words
    begin
      logic [31:0] bad [4];
      logic        bv [4];
      bad[0] = 32'h8000E68F; bv[0] = 1;
      bad[1] = 32'h8040E68E; bv[1] = 1;
      bad[2] = 32'h0000E68E; bv[2] = 1;
      bad[3] = mkword(3'd1, 3'd2); bv[3] = 0;
      for (int k = 0; k < 4; k++) begin
        load(3'd2, 32'h412CCCCD);
        issue_valid = bv[k]; issue_word = bad[k];
        @(negedge clk);
        issue_valid = 0; issue_word = 0;
        for (int c = 0; c < 3; c++) begin
          chk(wb_en == 0, "R1 ignored word", 32'(wb_en), 0);
          @(negedge clk);
        end
      end
    end

    // R9: back-to-back
    regs_flat = 0;
    regs_flat[1*32 +: 32] = 32'h412CCCCD;
    regs_flat[4*32 +: 32] = 32'h40600000;
    issue_valid = 1; issue_word = mkword(3'd6, 3'd1);
    @(negedge clk);
    issue_word = mkword(3'd0, 3'd4);
    chk(wb_en == 0, "R9 slot", 32'(wb_en), 0);
    @(negedge clk);
    issue_valid = 0; issue_word = 0;
    chk(wb_en == 1 && wb_idx == 6 && wb_data == 32'd11, "R9 first", wb_data, 32'd11);
    @(negedge clk);
    chk(wb_en == 1 && wb_idx == 0 && wb_data == 32'd4, "R9 second", wb_data, 32'd4);
    @(negedge clk);
    chk(wb_en == 0, "R9 end", 32'(wb_en), 0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule